// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one read or write burst, one address per clock. A start strobe loads a starting column together with a three-bit length code and an order bit. The block then walks through the burst: inside an aligned block of 1, 2, 4 or 8 columns, either by counting up with wrap-around or by XOR of the starting offset with the beat number. In page mode it instead keeps counting across the whole page, wrapping at the page end, and does not stop on its own.

A controller model or memory model drives `start` for every column command and `stop` for a burst-terminate command. A new start is taken on any clock and replaces the remaining beats of the running burst. While the clock-enable input is low, the whole block is frozen. A length code that is not defined, or page mode asked for with XOR order, still gives one address, and the block flags it.

The controller is a three-state machine. `ST_IDLE` means no burst. `ST_BLOCK` means a fixed-length burst is running. `ST_PAGE` means a page burst is running. The transitions are as follows:
- load: any state goes to `ST_BLOCK` or `ST_PAGE` when `start` is sampled with `ce` high.
- finish: `ST_BLOCK` goes to `ST_IDLE` after its final beat.
- abort: `ST_BLOCK` or `ST_PAGE` goes to `ST_IDLE` on `stop`.
- advance: the beat counter steps and the state stays the same.
- freeze: nothing changes while `ce` is low.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `busy`, `last` and `cfg_err` are low.
- R2: Length code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. 111 selects page mode. With `ce` held high, `busy` stays high for exactly that many cycles. `last` is high only on the final beat.
- R3: The first address appears in the cycle after `start` is sampled and equals `start_col`. Column bits above the block offset stay equal to `start_col` for the whole burst.
- R4: When `ilv` is 0, beat k has block offset (s + k) mod N. Here s is the starting offset and N is the burst length.
- R5: When `ilv` is 1, beat k has block offset s XOR k.
- R6: Page mode (code 111, `ilv` 0) outputs `start_col + k` modulo 2^COL_W. It never raises `last` and runs until it is stopped or restarted.
- R7: A `start` sampled during a burst drops the remaining beats. A complete new burst then begins from the new column in the next cycle.
- R8: A `stop` sampled with `ce` high makes `busy` low in the next cycle. If `start` is sampled in the same cycle, the start wins.
- R9: While `ce` is low, `col_out`, `busy` and `last` hold their values, and `start` and `stop` are ignored.
- R10: Length codes 100, 101 and 110, and code 111 with `ilv` 1, give a single beat at `start_col`. On that beat `cfg_err` and `last` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Clock enable; low freezes the block |
| start | input | 1 | Begin a new burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | Order: 0 counting up, 1 XOR |
| stop | input | 1 | Terminate the running burst |
| col_out | output | COL_W | Current column address, valid while busy |
| busy | output | 1 | A beat is being output this cycle |
| last | output | 1 | This beat is the final one of a fixed burst |
| cfg_err | output | 1 | The current burst came from an illegal setting |

## Verification
The hardest case to reach is a freeze that arrives in the middle of a burst while `start` and `stop` are both driven. Only there can a wrong priority between the enable, the restart and the stop show up. The bench opens an 8-beat burst and drops `ce` after the first beat, with a new column and both strobes raised for three cycles. It then releases everything and expects the original sequence to resume at its second beat. Restarts from page mode into an XOR burst, and a stop paired with a start, are also driven from mid-burst states.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLOCK = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_t;

    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       len_code,
    input  logic             ilv,
    output logic [COL_W-1:0] mask,
    output logic             page,
    output logic             err
);
    // Offset masks for the fixed lengths; page mode uses all ones.
    localparam logic [COL_W-1:0] M1 = COL_W'(0);
    localparam logic [COL_W-1:0] M2 = COL_W'(1);
    localparam logic [COL_W-1:0] M4 = COL_W'(3);
    localparam logic [COL_W-1:0] M8 = COL_W'(7);

    always_comb begin
        mask = M1;
        page = 1'b0;
        err  = 1'b0;
        unique case (len_code)
            LEN_ONE:   mask = M1;
            LEN_TWO:   mask = M2;
            LEN_FOUR:  mask = M4;
            LEN_EIGHT: mask = M8;
            LEN_PAGE: begin
                if (ilv) begin
                    err = 1'b1;
                end else begin
                    mask = '1;
                    page = 1'b1;
                end
            end
            default:   err = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  logic             ilv,
    input  logic [COL_W-1:0] dec_mask,
    input  logic             dec_page,
    input  logic             dec_err,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] mask_q,
    output logic [COL_W-1:0] beat_q,
    output logic             ilv_q,
    output logic             busy,
    output logic             last,
    output logic             cfg_err
);
    bcg_state_t state, nxt;
    logic       load, adv, err_q;

    // Next-state decision: freeze, load, abort, finish or advance.
    always_comb begin
        nxt  = state;
        load = 1'b0;
        adv  = 1'b0;
        if (ce) begin
            if (start) begin
                load = 1'b1;
                nxt  = dec_page ? ST_PAGE : ST_BLOCK;
            end else if (stop) begin
                nxt = ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE:  nxt = ST_IDLE;
                    ST_BLOCK: begin
                        if (beat_q == mask_q) nxt = ST_IDLE;
                        else                  adv = 1'b1;
                    end
                    ST_PAGE:  adv = 1'b1;
                    default:  nxt = ST_IDLE;
                endcase
            end
        end
    end

    // State and burst registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base_q <= '0;
            mask_q <= '0;
            beat_q <= '0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                base_q <= start_col;
                mask_q <= dec_mask;
                beat_q <= '0;
                ilv_q  <= ilv;
                err_q  <= dec_err;
            end else if (adv) begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end

    // Outputs from state.
    always_comb begin
        busy    = (state != ST_IDLE);
        last    = (state == ST_BLOCK) && (beat_q == mask_q);
        cfg_err = busy && err_q;
    end

    a_r6_page_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAGE) && ce && !start && !stop |=> (state == ST_PAGE));
    a_r10_err_block: assert property (@(posedge clk) disable iff (!rst_n)
        ce && start && dec_err |=> (state == ST_BLOCK) && (mask_q == '0));
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] mask,
    input  logic [COL_W-1:0] beat,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] off;

    generate
        if (COL_W < 3) begin : g_bad
            initial $error("COL_W must be at least 3");
        end
    endgenerate

    always_comb begin
        off = ilv ? (base ^ beat) : (base + beat);
        col = (base & ~mask) | (off & mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             ilv,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             busy,
    output logic             last,
    output logic             cfg_err
);
    logic [COL_W-1:0] dec_mask, base_q, mask_q, beat_q;
    logic             dec_page, dec_err, ilv_q;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code (len_code),
        .ilv      (ilv),
        .mask     (dec_mask),
        .page     (dec_page),
        .err      (dec_err)
    );

    bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .ilv       (ilv),
        .dec_mask  (dec_mask),
        .dec_page  (dec_page),
        .dec_err   (dec_err),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .beat_q    (beat_q),
        .ilv_q     (ilv_q),
        .busy      (busy),
        .last      (last),
        .cfg_err   (cfg_err)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base (base_q),
        .mask (mask_q),
        .beat (beat_q),
        .ilv  (ilv_q),
        .col  (col_out)
    );

    a_r9_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(col_out) && $stable(busy) && $stable(last));
    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ce && stop && !start |=> !busy);
    a_r7_restart_col: assert property (@(posedge clk) disable iff (!rst_n)
        ce && start |=> busy && (col_out == $past(start_col)));
    a_r2_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        ce && last && !start |=> !busy);
    a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> last);
    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (((col_out ^ base_q) & ~mask_q) == '0));
    a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ce && !start && !stop && !last && !ilv_q |=>
        col_out == ((($past(col_out) + COL_W'(1)) & $past(mask_q)) |
                    ($past(col_out) & ~$past(mask_q))));
endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
    localparam int CW   = 6;
    localparam int PAGE = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b1;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          ilv = 1'b0;
    logic [2:0]    len_code = 3'd0;
    logic [CW-1:0] start_col = '0;
    logic [CW-1:0] col_out;
    logic          busy, last, cfg_err;

    int total = 0;
    int bad = 0;

    burst_col_gen #(.COL_W(CW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .start     (start),
        .start_col (start_col),
        .len_code  (len_code),
        .ilv       (ilv),
        .stop      (stop),
        .col_out   (col_out),
        .busy      (busy),
        .last      (last),
        .cfg_err   (cfg_err)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int expc(int col, int n, bit il, int k);
        int m = n - 1;
        int off = il ? (col ^ k) : (col + k);
        return (col & ~m & (PAGE - 1)) | (off & m);
    endfunction

    // Drive a start at a falling edge; return at the falling edge where beat 0 is visible.
    task automatic fire(int col, int code, bit il);
        @(negedge clk);
        start     = 1'b1;
        start_col = CW'(col);
        len_code  = 3'(code);
        ilv       = il;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_fixed(int col, int code, bit il);
        int n = 1 << code;
        fire(col, code, il);
        for (int k = 0; k < n; k++) begin
            check(il ? "R5 order" : "R4 order", int'(col_out), expc(col, n, il, k));
            check("R2 busy", int'(busy), 1);
            check("R2 last", int'(last), (k == n - 1) ? 1 : 0);
            if (k == 0) check("R10 no err", int'(cfg_err), 0);
            @(negedge clk);
        end
        check("R2 end", int'(busy), 0);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 last", int'(last), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: all fixed lengths, both orders, every start column
        for (int code = 0; code < 4; code++)
            for (int il = 0; il < 2; il++)
                for (int col = 0; col < PAGE; col++)
                    run_fixed(col, code, il[0]);

        // R6: page burst wraps past the page end and never raises last
        fire(60, 7, 1'b0);
        for (int k = 0; k < 140; k++) begin
            check("R6 page col", int'(col_out), (60 + k) % PAGE);
            check("R6 no last", int'(last), 0);
            @(negedge clk);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R8 page stop", int'(busy), 0);

        // R7: restart inside an 8-beat burst with a 2-beat burst
        fire(3, 3, 1'b0);
        check("R7 pre", int'(col_out), 3);
        @(negedge clk);
        check("R7 pre", int'(col_out), 4);
        start = 1'b1; start_col = CW'(20); len_code = 3'd1; ilv = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R7 new first", int'(col_out), 20);
        check("R7 not last", int'(last), 0);
        @(negedge clk);
        check("R7 new second", int'(col_out), 21);
        check("R7 last", int'(last), 1);
        @(negedge clk);
        check("R7 done", int'(busy), 0);

        // R7: restart a page burst into a 4-beat XOR burst
        fire(10, 7, 1'b0);
        repeat (5) @(negedge clk);
        start = 1'b1; start_col = CW'(41); len_code = 3'd2; ilv = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R7 page restart", int'(col_out), expc(41, 4, 1'b1, k));
            @(negedge clk);
        end
        check("R7 page restart end", int'(busy), 0);

        // R8: stop and start together; start wins
        fire(0, 3, 1'b0);
        stop = 1'b1; start = 1'b1; start_col = CW'(33); len_code = 3'd0;
        @(negedge clk);
        stop = 1'b0; start = 1'b0;
        check("R8 start wins col", int'(col_out), 33);
        check("R8 start wins last", int'(last), 1);
        @(negedge clk);
        check("R8 start wins end", int'(busy), 0);

        // R8: plain stop in an XOR burst
        fire(16, 3, 1'b1);
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R8 stop", int'(busy), 0);

        // R9: freeze mid-burst with both strobes driven
        fire(8, 3, 1'b0);
        check("R9 first", int'(col_out), 8);
        ce = 1'b0; start = 1'b1; stop = 1'b1; start_col = CW'(50); len_code = 3'd0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 hold col", int'(col_out), 8);
            check("R9 hold busy", int'(busy), 1);
        end
        ce = 1'b1; start = 1'b0; stop = 1'b0;
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            check("R9 resume", int'(col_out), 8 + k);
        end
        @(negedge clk);
        check("R9 end", int'(busy), 0);

        // R9: start ignored while frozen and idle
        @(negedge clk);
        ce = 1'b0; start = 1'b1; start_col = CW'(5); len_code = 3'd3;
        @(negedge clk);
        ce = 1'b1; start = 1'b0;
        check("R9 idle start ignored", int'(busy), 0);
        @(negedge clk);
        check("R9 idle stays", int'(busy), 0);

        // R10: illegal settings give one flagged beat
        for (int code = 4; code < 8; code++) begin
            fire(37, code, (code == 7));
            check("R10 col", int'(col_out), 37);
            check("R10 err", int'(cfg_err), 1);
            check("R10 last", int'(last), 1);
            @(negedge clk);
            check("R10 end", int'(busy), 0);
            check("R10 err clear", int'(cfg_err), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule